// File: doc/BRIEF.md
# Reservation Station Wakeup and Select

This block holds a small pool of waiting instructions for a single functional unit in an out-of-order core that uses Tomasulo-style scheduling. Each dispatched instruction brings an opcode, a destination tag and two source operands. A source is either a value that is already known, taken from the architected register file, or the tag of the instruction that will produce it.

The pool watches the result broadcast bus every cycle. When a broadcast tag matches a pending source of an occupied entry, the entry copies the broadcast value and marks that source ready. Issue happens in two steps. Wakeup marks every entry whose two sources both hold values. Select then uses a fixed-priority encoder to pick one woken entry, which goes out to the functional unit when the unit signals that it is free. The issued entry is released at that clock edge. A full flag tells the dispatch stage to stall.

Top module: `rs_wakeup_select`

## Requirements
- R1: While `rst_ni` is low, every entry is cleared to free. After reset, `full_o` and `issue_valid_o` are 0.
- R2: A dispatch is written into the lowest-numbered free entry at the clock edge where `disp_valid_i` is high.
- R3: A source dispatched with its ready bit set to 1 keeps the supplied value, and its tag is ignored.
- R4: A valid broadcast whose tag equals a pending source tag of an occupied entry loads the broadcast value into that source and marks it ready. Both sources of every entry are compared independently.
- R5: An entry is woken once both of its sources are ready. `issue_valid_o` is high in the same cycle, combinationally, whenever `fu_ready_i` is high and at least one entry is woken. It is never high while `fu_ready_i` is low.
- R6: When more than one entry is woken, the lowest-numbered one is selected. At most one entry issues per cycle. `issue_op_o`, `issue_dest_o`, `issue_src1_o` and `issue_src2_o` carry the fields of that entry.
- R7: An entry is freed at the clock edge where it issues. While `fu_ready_i` is low, no entry is freed and woken entries keep waiting.
- R8: A pending source dispatched in the same cycle as a valid broadcast carrying its tag captures the broadcast value, and the new entry is woken from the next cycle.
- R9: `full_o` is high exactly when every entry is occupied. A dispatch while `full_o` is high is dropped and changes no entry.
- R10: A broadcast with `cdb_valid_i` low, or one whose tag matches no pending source, leaves every source unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| disp_valid_i | input | 1 | Dispatch request |
| disp_op_i | input | OP_W | Opcode of the dispatched instruction |
| disp_dest_i | input | TAG_W | Destination tag |
| disp_src1_rdy_i | input | 1 | Source 1 holds a value (1) or waits on a tag (0) |
| disp_src1_tag_i | input | TAG_W | Producer tag of source 1 |
| disp_src1_val_i | input | DATA_W | Value of source 1 |
| disp_src2_rdy_i | input | 1 | Source 2 holds a value (1) or waits on a tag (0) |
| disp_src2_tag_i | input | TAG_W | Producer tag of source 2 |
| disp_src2_val_i | input | DATA_W | Value of source 2 |
| cdb_valid_i | input | 1 | Result broadcast valid |
| cdb_tag_i | input | TAG_W | Result broadcast tag |
| cdb_val_i | input | DATA_W | Result broadcast value |
| fu_ready_i | input | 1 | Functional unit can accept an instruction |
| issue_valid_o | output | 1 | An instruction is issued this cycle |
| issue_op_o | output | OP_W | Opcode of the issued instruction |
| issue_dest_o | output | TAG_W | Destination tag of the issued instruction |
| issue_src1_o | output | DATA_W | Source 1 value of the issued instruction |
| issue_src2_o | output | DATA_W | Source 2 value of the issued instruction |
| full_o | output | 1 | No free entry |

## Verification
The assertions assume that every input is known after reset. They do not assume that producer tags are unique, so more than one entry may wait on the same tag and capture the same broadcast. The stimulus draws tags from a narrow pool of eight values so that matches, same-cycle dispatch captures and shared waits happen often. It holds `fu_ready_i` low about a quarter of the time, which lets the bank fill up and exercises dispatch while full. Directed sequences cover the cases that random stimulus rarely reaches: a broadcast in the same cycle as the dispatch it feeds, a full bank, and reuse of a freed entry out of order.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int unsigned DEF_ENTRIES = 8;
  localparam int unsigned DEF_TAG_W   = 4;
  localparam int unsigned DEF_DATA_W  = 16;
  localparam int unsigned DEF_OP_W    = 4;

  function automatic int unsigned idx_width(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rs_src_slot.sv
module rs_src_slot #(
  parameter int unsigned TAG_W  = rs_pkg::DEF_TAG_W,
  parameter int unsigned DATA_W = rs_pkg::DEF_DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              load_i,
  input  logic              ld_rdy_i,
  input  logic [TAG_W-1:0]  ld_tag_i,
  input  logic [DATA_W-1:0] ld_val_i,
  input  logic              cdb_valid_i,
  input  logic [TAG_W-1:0]  cdb_tag_i,
  input  logic [DATA_W-1:0] cdb_val_i,
  output logic              rdy_o,
  output logic [DATA_W-1:0] val_o
);
  logic              rdy_q;
  logic [TAG_W-1:0]  tag_q;
  logic [DATA_W-1:0] val_q;
  logic              hit_load, hit_held;

  // same-cycle bypass for a source being dispatched
  assign hit_load = cdb_valid_i && (cdb_tag_i == ld_tag_i);
  assign hit_held = cdb_valid_i && active_i && !rdy_q && (cdb_tag_i == tag_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q <= 1'b0;
      tag_q <= '0;
      val_q <= '0;
    end else if (load_i) begin
      tag_q <= ld_tag_i;
      if (ld_rdy_i) begin
        rdy_q <= 1'b1;
        val_q <= ld_val_i;
      end else if (hit_load) begin
        rdy_q <= 1'b1;
        val_q <= cdb_val_i;
      end else begin
        rdy_q <= 1'b0;
      end
    end else if (hit_held) begin
      rdy_q <= 1'b1;
      val_q <= cdb_val_i;
    end
  end

  assign rdy_o = rdy_q;
  assign val_o = val_q;
endmodule

// File: rtl/rs_entry.sv
module rs_entry #(
  parameter int unsigned TAG_W  = rs_pkg::DEF_TAG_W,
  parameter int unsigned DATA_W = rs_pkg::DEF_DATA_W,
  parameter int unsigned OP_W   = rs_pkg::DEF_OP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  logic              free_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [TAG_W-1:0]  dest_i,
  input  logic [1:0]        src_rdy_i,
  input  logic [TAG_W-1:0]  src_tag_i [2],
  input  logic [DATA_W-1:0] src_val_i [2],
  input  logic              cdb_valid_i,
  input  logic [TAG_W-1:0]  cdb_tag_i,
  input  logic [DATA_W-1:0] cdb_val_i,
  output logic              busy_o,
  output logic              woken_o,
  output logic [OP_W-1:0]   op_o,
  output logic [TAG_W-1:0]  dest_o,
  output logic [DATA_W-1:0] src_val_o [2]
);
  logic             busy_q;
  logic [OP_W-1:0]  op_q;
  logic [TAG_W-1:0] dest_q;
  logic [1:0]       src_rdy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      op_q   <= '0;
      dest_q <= '0;
    end else if (alloc_i) begin
      busy_q <= 1'b1;
      op_q   <= op_i;
      dest_q <= dest_i;
    end else if (free_i) begin
      busy_q <= 1'b0;
    end
  end

  for (genvar s = 0; s < 2; s++) begin : g_src
    rs_src_slot #(.TAG_W(TAG_W), .DATA_W(DATA_W)) i_slot (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .active_i    (busy_q),
      .load_i      (alloc_i),
      .ld_rdy_i    (src_rdy_i[s]),
      .ld_tag_i    (src_tag_i[s]),
      .ld_val_i    (src_val_i[s]),
      .cdb_valid_i (cdb_valid_i),
      .cdb_tag_i   (cdb_tag_i),
      .cdb_val_i   (cdb_val_i),
      .rdy_o       (src_rdy[s]),
      .val_o       (src_val_o[s])
    );
  end

  assign busy_o  = busy_q;
  assign woken_o = busy_q && (&src_rdy);
  assign op_o    = op_q;
  assign dest_o  = dest_q;
endmodule

// File: rtl/rs_select.sv
module rs_select #(
  parameter int unsigned N     = rs_pkg::DEF_ENTRIES,
  parameter int unsigned IDX_W = rs_pkg::idx_width(N)
) (
  input  logic [N-1:0]     req_i,
  output logic [N-1:0]     grant_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  // fixed priority: bit 0 wins
  always_comb begin
    grant_o = '0;
    idx_o   = '0;
    any_o   = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && !any_o) begin
        grant_o[i] = 1'b1;
        idx_o      = IDX_W'(i);
        any_o      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rs_wakeup_select.sv
module rs_wakeup_select #(
  parameter int unsigned NUM_ENTRIES = rs_pkg::DEF_ENTRIES,
  parameter int unsigned TAG_W       = rs_pkg::DEF_TAG_W,
  parameter int unsigned DATA_W      = rs_pkg::DEF_DATA_W,
  parameter int unsigned OP_W        = rs_pkg::DEF_OP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              disp_valid_i,
  input  logic [OP_W-1:0]   disp_op_i,
  input  logic [TAG_W-1:0]  disp_dest_i,
  input  logic              disp_src1_rdy_i,
  input  logic [TAG_W-1:0]  disp_src1_tag_i,
  input  logic [DATA_W-1:0] disp_src1_val_i,
  input  logic              disp_src2_rdy_i,
  input  logic [TAG_W-1:0]  disp_src2_tag_i,
  input  logic [DATA_W-1:0] disp_src2_val_i,
  input  logic              cdb_valid_i,
  input  logic [TAG_W-1:0]  cdb_tag_i,
  input  logic [DATA_W-1:0] cdb_val_i,
  input  logic              fu_ready_i,
  output logic              issue_valid_o,
  output logic [OP_W-1:0]   issue_op_o,
  output logic [TAG_W-1:0]  issue_dest_o,
  output logic [DATA_W-1:0] issue_src1_o,
  output logic [DATA_W-1:0] issue_src2_o,
  output logic              full_o
);
  localparam int unsigned IDX_W = rs_pkg::idx_width(NUM_ENTRIES);

  logic [NUM_ENTRIES-1:0] busy_vec, woken_vec;
  logic [NUM_ENTRIES-1:0] alloc_grant, issue_grant;
  logic [NUM_ENTRIES-1:0] alloc_vec, free_vec;
  logic [IDX_W-1:0]       alloc_idx, issue_idx;
  logic                   alloc_any, issue_any, disp_fire, issue_fire;

  logic [OP_W-1:0]   op_arr   [NUM_ENTRIES];
  logic [TAG_W-1:0]  dest_arr [NUM_ENTRIES];
  logic [DATA_W-1:0] src1_arr [NUM_ENTRIES];
  logic [DATA_W-1:0] src2_arr [NUM_ENTRIES];

  logic [TAG_W-1:0]  disp_tags [2];
  logic [DATA_W-1:0] disp_vals [2];

  assign disp_tags[0] = disp_src1_tag_i;
  assign disp_tags[1] = disp_src2_tag_i;
  assign disp_vals[0] = disp_src1_val_i;
  assign disp_vals[1] = disp_src2_val_i;

  rs_select #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) i_alloc_sel (
    .req_i   (~busy_vec),
    .grant_o (alloc_grant),
    .idx_o   (alloc_idx),
    .any_o   (alloc_any)
  );

  rs_select #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) i_issue_sel (
    .req_i   (woken_vec),
    .grant_o (issue_grant),
    .idx_o   (issue_idx),
    .any_o   (issue_any)
  );

  assign full_o     = !alloc_any;
  assign disp_fire  = disp_valid_i && alloc_any;
  assign issue_fire = issue_any && fu_ready_i;
  assign alloc_vec  = alloc_grant & {NUM_ENTRIES{disp_fire}};
  assign free_vec   = issue_grant & {NUM_ENTRIES{issue_fire}};

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_entry
    logic [DATA_W-1:0] vals [2];

    rs_entry #(.TAG_W(TAG_W), .DATA_W(DATA_W), .OP_W(OP_W)) i_entry (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .alloc_i     (alloc_vec[e]),
      .free_i      (free_vec[e]),
      .op_i        (disp_op_i),
      .dest_i      (disp_dest_i),
      .src_rdy_i   ({disp_src2_rdy_i, disp_src1_rdy_i}),
      .src_tag_i   (disp_tags),
      .src_val_i   (disp_vals),
      .cdb_valid_i (cdb_valid_i),
      .cdb_tag_i   (cdb_tag_i),
      .cdb_val_i   (cdb_val_i),
      .busy_o      (busy_vec[e]),
      .woken_o     (woken_vec[e]),
      .op_o        (op_arr[e]),
      .dest_o      (dest_arr[e]),
      .src_val_o   (vals)
    );

    assign src1_arr[e] = vals[0];
    assign src2_arr[e] = vals[1];
  end

  assign issue_valid_o = issue_fire;
  assign issue_op_o    = op_arr[issue_idx];
  assign issue_dest_o  = dest_arr[issue_idx];
  assign issue_src1_o  = src1_arr[issue_idx];
  assign issue_src2_o  = src2_arr[issue_idx];
endmodule

// File: rtl/rs_wakeup_select_chk.sv
module rs_wakeup_select_chk #(
  parameter int unsigned N     = rs_pkg::DEF_ENTRIES,
  parameter int unsigned IDX_W = rs_pkg::idx_width(N)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             fu_ready_i,
  input logic             issue_valid_o,
  input logic             full_o,
  input logic [N-1:0]     busy_q,
  input logic [N-1:0]     woken,
  input logic [N-1:0]     grant,
  input logic [IDX_W-1:0] issue_idx
);
  a_r5_issue_needs_fu: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o |-> fu_ready_i);

  a_r5_woken_issues: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fu_ready_i && (|woken)) |-> issue_valid_o);

  a_r6_one_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant));

  a_r6_lowest_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant != '0) |-> (((grant - 1'b1) & woken) == '0));

  a_r7_issued_freed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o |=> !busy_q[$past(issue_idx)]);

  a_r7_no_free_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_valid_o |=> ((busy_q & $past(busy_q)) == $past(busy_q)));

  a_r9_full_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !issue_valid_o) |=> full_o);
endmodule

bind rs_wakeup_select rs_wakeup_select_chk #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) i_rs_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .fu_ready_i    (fu_ready_i),
  .issue_valid_o (issue_valid_o),
  .full_o        (full_o),
  .busy_q        (busy_vec),
  .woken         (woken_vec),
  .grant         (issue_grant),
  .issue_idx     (issue_idx)
);

// File: tb/test_rs_wakeup_select.sv
module test_rs_wakeup_select;
  localparam int N      = 8;
  localparam int TAG_W  = 4;
  localparam int DATA_W = 16;
  localparam int OP_W   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic disp_v = 1'b0, s1_rdy = 1'b0, s2_rdy = 1'b0, cdb_v = 1'b0, fu_rdy = 1'b0;
  logic [OP_W-1:0]   d_op = '0;
  logic [TAG_W-1:0]  d_dest = '0, s1_tag = '0, s2_tag = '0, cdb_tag = '0;
  logic [DATA_W-1:0] s1_val = '0, s2_val = '0, cdb_val = '0;
  logic              iss_v, full;
  logic [OP_W-1:0]   iss_op;
  logic [TAG_W-1:0]  iss_dest;
  logic [DATA_W-1:0] iss_s1, iss_s2;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  // reference model state
  bit                m_busy [N];
  bit                m_r1 [N], m_r2 [N];
  logic [OP_W-1:0]   m_op [N];
  logic [TAG_W-1:0]  m_dest [N], m_t1 [N], m_t2 [N];
  logic [DATA_W-1:0] m_v1 [N], m_v2 [N];

  always #2.5 clk = ~clk;

  rs_wakeup_select #(.NUM_ENTRIES(N), .TAG_W(TAG_W), .DATA_W(DATA_W), .OP_W(OP_W)) i_rs_wakeup_select (
    .clk_i(clk), .rst_ni(rst_n),
    .disp_valid_i(disp_v), .disp_op_i(d_op), .disp_dest_i(d_dest),
    .disp_src1_rdy_i(s1_rdy), .disp_src1_tag_i(s1_tag), .disp_src1_val_i(s1_val),
    .disp_src2_rdy_i(s2_rdy), .disp_src2_tag_i(s2_tag), .disp_src2_val_i(s2_val),
    .cdb_valid_i(cdb_v), .cdb_tag_i(cdb_tag), .cdb_val_i(cdb_val),
    .fu_ready_i(fu_rdy),
    .issue_valid_o(iss_v), .issue_op_o(iss_op), .issue_dest_o(iss_dest),
    .issue_src1_o(iss_s1), .issue_src2_o(iss_s2), .full_o(full)
  );

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic bit m_full();
    for (int i = 0; i < N; i++) if (!m_busy[i]) return 1'b0;
    return 1'b1;
  endfunction

  // check outputs mid-cycle, then advance the model at the edge
  task automatic step(input string tag);
    bit exp_full, exp_valid, found;
    int sel, alloc;
    @(negedge clk);
    #1;
    exp_full = m_full();
    found = 1'b0; sel = 0;
    for (int i = 0; i < N; i++)
      if (!found && m_busy[i] && m_r1[i] && m_r2[i]) begin found = 1'b1; sel = i; end
    exp_valid = fu_rdy && found;
    chk(full === exp_full, {tag, " R9 full_o"}, full, exp_full);
    chk(iss_v === exp_valid, {tag, " R5 issue_valid_o"}, iss_v, exp_valid);
    if (exp_valid && iss_v === 1'b1) begin
      chk(iss_op === m_op[sel], {tag, " R6 issue_op_o"}, iss_op, m_op[sel]);
      chk(iss_dest === m_dest[sel], {tag, " R6 issue_dest_o"}, iss_dest, m_dest[sel]);
      chk(iss_s1 === m_v1[sel], {tag, " R4 issue_src1_o"}, iss_s1, m_v1[sel]);
      chk(iss_s2 === m_v2[sel], {tag, " R4 issue_src2_o"}, iss_s2, m_v2[sel]);
    end
    @(posedge clk);
    alloc = -1;
    if (disp_v && !exp_full)
      for (int i = N - 1; i >= 0; i--) if (!m_busy[i]) alloc = i;
    for (int i = 0; i < N; i++) if (m_busy[i] && cdb_v) begin
      if (!m_r1[i] && m_t1[i] == cdb_tag) begin m_r1[i] = 1'b1; m_v1[i] = cdb_val; end
      if (!m_r2[i] && m_t2[i] == cdb_tag) begin m_r2[i] = 1'b1; m_v2[i] = cdb_val; end
    end
    if (exp_valid) m_busy[sel] = 1'b0;
    if (alloc >= 0) begin
      m_busy[alloc] = 1'b1; m_op[alloc] = d_op; m_dest[alloc] = d_dest;
      m_t1[alloc] = s1_tag; m_t2[alloc] = s2_tag;
      if (s1_rdy) begin m_r1[alloc] = 1'b1; m_v1[alloc] = s1_val; end
      else if (cdb_v && cdb_tag == s1_tag) begin m_r1[alloc] = 1'b1; m_v1[alloc] = cdb_val; end
      else m_r1[alloc] = 1'b0;
      if (s2_rdy) begin m_r2[alloc] = 1'b1; m_v2[alloc] = s2_val; end
      else if (cdb_v && cdb_tag == s2_tag) begin m_r2[alloc] = 1'b1; m_v2[alloc] = cdb_val; end
      else m_r2[alloc] = 1'b0;
    end
    #1;
  endtask

  task automatic disp(input logic [OP_W-1:0] op, input logic [TAG_W-1:0] dst,
                      input bit r1, input logic [TAG_W-1:0] t1, input logic [DATA_W-1:0] v1,
                      input bit r2, input logic [TAG_W-1:0] t2, input logic [DATA_W-1:0] v2);
    disp_v = 1'b1; d_op = op; d_dest = dst;
    s1_rdy = r1; s1_tag = t1; s1_val = v1;
    s2_rdy = r2; s2_tag = t2; s2_val = v2;
  endtask

  task automatic bcast(input logic [TAG_W-1:0] t, input logic [DATA_W-1:0] v);
    cdb_v = 1'b1; cdb_tag = t; cdb_val = v;
  endtask

  task automatic idle();
    disp_v = 1'b0; cdb_v = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d2c));
    for (int i = 0; i < N; i++) begin
      m_busy[i] = 0; m_r1[i] = 0; m_r2[i] = 0;
      m_op[i] = '0; m_dest[i] = '0; m_t1[i] = '0; m_t2[i] = '0; m_v1[i] = '0; m_v2[i] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: idle after reset even with the unit free
    fu_rdy = 1'b1; idle(); step("R1");
    chk(full === 1'b0 && iss_v === 1'b0, "R1 reset state", {full, iss_v}, 0);

    // R3: ready sources keep their values, tags ignored
    fu_rdy = 1'b0; disp(4'h3, 4'h5, 1, 4'h7, 16'h0011, 1, 4'h9, 16'h0022); step("R3");
    idle(); fu_rdy = 1'b1; step("R3"); step("R3");

    // R8: broadcast in the dispatch cycle feeds the new entry
    fu_rdy = 1'b0; disp(4'h4, 4'h6, 0, 4'h6, 16'h0, 1, 4'h0, 16'h0033);
    bcast(4'h6, 16'h0066); step("R8");
    idle(); fu_rdy = 1'b1; step("R8");

    // R10: unrelated or invalid broadcasts leave sources pending
    disp(4'h5, 4'h7, 0, 4'h2, 16'h0, 0, 4'h3, 16'h0); step("R10");
    idle(); bcast(4'h4, 16'h0444); step("R10");
    cdb_v = 1'b0; cdb_tag = 4'h2; step("R10");
    bcast(4'h2, 16'h00aa); step("R4");
    bcast(4'h3, 16'h00bb); step("R4");
    idle(); step("R5");

    // R7 and R2: hold while unit busy, then reuse of a freed middle entry
    fu_rdy = 1'b0;
    disp(4'h1, 4'h1, 0, 4'h1, 0, 1, 0, 16'h0101); step("R2");
    disp(4'h2, 4'h2, 0, 4'h2, 0, 1, 0, 16'h0202); step("R2");
    disp(4'h3, 4'h3, 0, 4'h3, 0, 1, 0, 16'h0303); step("R2");
    idle(); bcast(4'h2, 16'h1212); step("R7");
    idle(); step("R7"); step("R7");
    fu_rdy = 1'b1; step("R7");
    fu_rdy = 1'b0; disp(4'h9, 4'h9, 1, 0, 16'h0909, 1, 0, 16'h0990); step("R2");
    idle(); bcast(4'h1, 16'h1111); step("R2");
    bcast(4'h3, 16'h3333); step("R2");
    idle(); fu_rdy = 1'b1;
    for (int k = 0; k < 4; k++) step("R6");

    // R9: fill the bank, dispatch while full is dropped
    fu_rdy = 1'b0;
    for (int k = 0; k < N; k++) begin
      disp(OP_W'(k), TAG_W'(k), 0, 4'hf, 0, 1, 0, DATA_W'(k));
      step("R9");
    end
    disp(4'hc, 4'hc, 1, 0, 16'hcccc, 1, 0, 16'hcccc); step("R9");
    chk(full === 1'b1, "R9 full after fill", full, 1);
    idle(); bcast(4'hf, 16'h00ff); step("R9");
    idle(); fu_rdy = 1'b1;
    for (int k = 0; k < N + 1; k++) step("R6");
    chk(full === 1'b0 && iss_v === 1'b0, "R9 dropped dispatch left no entry", {full, iss_v}, 0);

    // random mix
    for (int k = 0; k < 4000; k++) begin
      fu_rdy = ($urandom % 4) != 0;
      disp_v = ($urandom % 3) != 0;
      d_op = OP_W'($urandom); d_dest = TAG_W'($urandom % 8);
      s1_rdy = ($urandom % 2) != 0; s1_tag = TAG_W'($urandom % 8); s1_val = DATA_W'($urandom);
      s2_rdy = ($urandom % 2) != 0; s2_tag = TAG_W'($urandom % 8); s2_val = DATA_W'($urandom);
      cdb_v = ($urandom % 2) != 0; cdb_tag = TAG_W'($urandom % 8); cdb_val = DATA_W'($urandom);
      step("RND");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule